// File: doc/BRIEF.md
# Multiplexed ADC Serial Sequencer

This block is the digital control side of a four-channel, 12-bit sampling converter with a synchronous serial port. A host drives a serial clock, an active-low select, a data-in line, a power-down input and a mode input. The block counts the serial clocks of each frame and freezes the sample of the chosen channel when a frame starts. It then shifts the result out MSB first on a data line that has an enable. It also takes the channel code for the next conversion from the data-in line. The analog path is replaced by one parallel sample bus per channel.

The block runs on a fast system clock. The serial clock and the select line are sampled inputs, and the block acts on their edges. There are two modes. In slave mode the host lowers select once per frame. In free-running mode select stays low and a dead seventeenth clock leads into the next frame. STATUS is high while a conversion is under way.

Top module: `muxadc_seq`

## Requirements
- R1: After synchronous reset, `chan` is 0 (CH0), `status` is 0 and `dout_en` is 0.
- R2: While `cs_n` is high, `status` and `dout_en` are 0 from the next system clock on. The latched channel in `chan` keeps its value.
- R3: A falling edge of `cs_n` while `shdn` is low starts a frame. It raises `status` and copies the sample bus lane of the current `chan` into a hold register. Changes on the bus after that point do not alter the shifted word.
- R4: `dout_en` is 0 after serial rising edges 1 to 4. The falling edges of serial clocks 4 to 15 drive data bits D11 down to D0, one bit per edge, with `dout_en` at 1, so each bit is stable at rising edges 5 to 16. The falling edge of clock 16 drops `dout_en`.
- R5: `dout` changes only in the system cycle after a detected falling edge of `sclk`.
- R6: `din` is read at serial rising edges 1 and 2. The first bit is the MSB of the channel code. Code 00 is CH0, 01 is CH1, 10 is CH2 and 11 is CH3. `chan` takes the code after rising edge 2. The code steers the next frame's sample, not the current one.
- R7: `status` stays 1 through falling edges 1 to 15 and falls after the falling edge of clock 16.
- R8: With `free_run` at 1 and `cs_n` low, a seventeenth clock follows the 16-clock frame. During it `status` and `dout_en` stay 0. Its falling edge starts the next frame, raising `status` and capturing the lane of the updated `chan`.
- R9: With `free_run` at 0, serial clocks after clock 16 start no frame. `status` and `dout_en` stay 0.
- R10: While `shdn` is high, `status` and `dout_en` are 0 from the next system clock on, which aborts any frame. After `shdn` returns low, serial clocks start no frame until `cs_n` falls again.
- R11: A falling edge of `cs_n` while `shdn` is high starts no frame. It does not start one later either, when `shdn` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, sampled on `clk` |
| cs_n | input | 1 | Active-low select; high clears the frame logic |
| din | input | 1 | Serial channel-code input |
| shdn | input | 1 | Power-down; high aborts the frame |
| free_run | input | 1 | 1 selects free-running mode, 0 selects slave mode |
| samp_bus | input | 48 | Four 12-bit sample lanes, lane i at bits [12i+11:12i] |
| dout | output | 1 | Serial result bit |
| dout_en | output | 1 | Drive enable for `dout`; 0 means high impedance |
| status | output | 1 | Conversion in progress |
| chan | output | 2 | Channel latched for the next conversion |

## Verification
In free-running mode, the falling edge of the dead seventeenth clock both ends one frame and starts the next. In that same system cycle the hold register takes the lane that the channel code just received points to. The bench sets a fresh bus value just before that edge and scrambles the bus right after it. It then judges the whole next word against the lane it saved in its own model. The bench also aborts a frame with power-down or with select in the middle of shifting. A second collision is a select fall while power-down is high. The bench checks that `status` and the enable stay low, even once power-down drops.

// File: rtl/muxadc_seq_pkg.sv
package muxadc_seq_pkg;

    localparam int unsigned DEF_NCH  = 4;
    localparam int unsigned DEF_DW   = 12;
    localparam int unsigned DEF_LEAD = 4;

    // edge events seen on the sampled serial inputs
    typedef struct packed {
        logic rise;
        logic fall;
        logic cs_fall;
    } edge_ev_t;

    function automatic int unsigned sel_width(input int unsigned nch);
        return (nch > 1) ? $clog2(nch) : 1;
    endfunction

endpackage

// File: rtl/muxadc_seq_edge.sv
module muxadc_seq_edge
    import muxadc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk,
    input  logic     cs_n,
    output edge_ev_t ev
);

    logic sclk_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    always_comb begin
        ev.rise    = sclk & ~sclk_q;
        ev.fall    = ~sclk & sclk_q;
        ev.cs_fall = ~cs_n & cs_q;
    end

endmodule

// File: rtl/muxadc_seq_ctrl.sv
module muxadc_seq_ctrl
    import muxadc_seq_pkg::*;
#(
    parameter int unsigned NCH  = DEF_NCH,
    parameter int unsigned DW   = DEF_DW,
    parameter int unsigned LEAD = DEF_LEAD,
    localparam int unsigned SELW  = sel_width(NCH),
    localparam int unsigned FRAME = LEAD + DW,
    localparam int unsigned CW    = $clog2(FRAME + 2)
) (
    input  logic            clk,
    input  logic            rst,
    input  edge_ev_t        ev,
    input  logic            clr,
    input  logic            free_run,
    input  logic            din,
    output logic [CW-1:0]   cnt,
    output logic            start,
    output logic            status,
    output logic [SELW-1:0] chan
);

    localparam logic [CW-1:0] LAST_CNT = CW'(FRAME);
    localparam logic [CW-1:0] DEAD_CNT = CW'(FRAME + 1);
    localparam logic [CW-1:0] SEL_CNT  = CW'(SELW);

    logic            active;
    logic [SELW-1:0] sel_acc;
    logic [SELW:0]   sel_cat;

    assign sel_cat = {sel_acc, din};
    assign start   = !clr && (ev.cs_fall ||
                     (free_run && active && ev.fall && cnt == DEAD_CNT));

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cnt     <= '0;
            status  <= 1'b0;
            chan    <= '0;
            sel_acc <= '0;
        end else if (clr) begin
            active <= 1'b0;
            cnt    <= '0;
            status <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
            status <= 1'b1;
        end else begin
            if (active && ev.rise && cnt != DEAD_CNT) begin
                cnt <= cnt + 1'b1;
                if (cnt < SEL_CNT)
                    sel_acc <= sel_cat[SELW-1:0];
                if (cnt == SEL_CNT - 1'b1)
                    chan <= sel_cat[SELW-1:0];
            end
            if (active && ev.fall && cnt == LAST_CNT)
                status <= 1'b0;
        end
    end

    AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (rst)
        clr |=> !status);                                    // R2
    AST_CHAN_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !ev.rise |=> $stable(chan));                         // R6
    AST_START_RAISES: assert property (@(posedge clk) disable iff (rst)
        start |=> status);                                   // R3
    AST_STATUS_DROP: assert property (@(posedge clk) disable iff (rst)
        (status && !clr && !ev.fall) |=> status);            // R7

endmodule

// File: rtl/muxadc_seq_shift.sv
module muxadc_seq_shift
    import muxadc_seq_pkg::*;
#(
    parameter int unsigned NCH  = DEF_NCH,
    parameter int unsigned DW   = DEF_DW,
    parameter int unsigned LEAD = DEF_LEAD,
    localparam int unsigned SELW  = sel_width(NCH),
    localparam int unsigned LANES = 1 << SELW,
    localparam int unsigned FRAME = LEAD + DW,
    localparam int unsigned CW    = $clog2(FRAME + 2)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            start,
    input  logic            fall,
    input  logic [CW-1:0]   cnt,
    input  logic [SELW-1:0] chan,
    input  logic [NCH*DW-1:0] samp_bus,
    output logic            dout,
    output logic            dout_en
);

    localparam logic [CW-1:0] LEAD_CNT = CW'(LEAD);
    localparam logic [CW-1:0] LAST_CNT = CW'(FRAME);

    logic [DW-1:0] lane [LANES];
    logic [DW-1:0] hold;
    logic [CW-1:0] bit_pos;
    logic          in_window;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < NCH) begin : g_real
            assign lane[i] = samp_bus[i*DW +: DW];
        end else begin : g_pad
            assign lane[i] = '0;
        end
    end

    assign in_window = (cnt >= LEAD_CNT) && (cnt < LAST_CNT);
    assign bit_pos   = LAST_CNT - 1'b1 - cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold    <= '0;
            dout    <= 1'b0;
            dout_en <= 1'b0;
        end else if (clr) begin
            dout_en <= 1'b0;
        end else if (start) begin
            hold    <= lane[chan];
            dout_en <= 1'b0;
        end else if (fall) begin
            if (in_window) begin
                dout_en <= 1'b1;
                dout    <= hold[bit_pos[$clog2(DW)-1:0]];
            end else if (cnt == LAST_CNT) begin
                dout_en <= 1'b0;
            end
        end
    end

    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(dout));                            // R5
    AST_EN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (cnt >= LEAD_CNT && cnt <= LAST_CNT));   // R4
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        clr |=> !dout_en);                                   // R2

endmodule

// File: rtl/muxadc_seq.sv
module muxadc_seq
    import muxadc_seq_pkg::*;
#(
    parameter int unsigned NCH  = DEF_NCH,
    parameter int unsigned DW   = DEF_DW,
    parameter int unsigned LEAD = DEF_LEAD,
    localparam int unsigned SELW  = sel_width(NCH),
    localparam int unsigned FRAME = LEAD + DW,
    localparam int unsigned CW    = $clog2(FRAME + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    input  logic              shdn,
    input  logic              free_run,
    input  logic [NCH*DW-1:0] samp_bus,
    output logic              dout,
    output logic              dout_en,
    output logic              status,
    output logic [SELW-1:0]   chan
);

    edge_ev_t      ev;
    logic          clr;
    logic          start;
    logic [CW-1:0] cnt;

    assign clr = cs_n | shdn;

    muxadc_seq_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .cs_n (cs_n),
        .ev   (ev)
    );

    muxadc_seq_ctrl #(.NCH(NCH), .DW(DW), .LEAD(LEAD)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .clr      (clr),
        .free_run (free_run),
        .din      (din),
        .cnt      (cnt),
        .start    (start),
        .status   (status),
        .chan     (chan)
    );

    muxadc_seq_shift #(.NCH(NCH), .DW(DW), .LEAD(LEAD)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .start    (start),
        .fall     (ev.fall),
        .cnt      (cnt),
        .chan     (chan),
        .samp_bus (samp_bus),
        .dout     (dout),
        .dout_en  (dout_en)
    );

    AST_SHDN_ABORT: assert property (@(posedge clk) disable iff (rst)
        shdn |=> (!status && !dout_en));                     // R10

endmodule

// File: tb/muxadc_seq_bench.sv
module muxadc_seq_bench;

    localparam int NCH  = 4;
    localparam int DW   = 12;
    localparam int SELW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic din = 1'b0;
    logic shdn = 1'b0;
    logic free_run = 1'b0;
    logic [NCH*DW-1:0] samp_bus = '0;
    logic dout, dout_en, status;
    logic [SELW-1:0] chan;

    int checks = 0;
    int fails = 0;
    logic [SELW-1:0] chan_m = '0;
    logic [DW-1:0] exp_word = '0;

    always #5 clk = ~clk;

    muxadc_seq u_muxadc_seq (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
        .shdn(shdn), .free_run(free_run), .samp_bus(samp_bus),
        .dout(dout), .dout_en(dout_en), .status(status), .chan(chan)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] lane_of(input logic [NCH*DW-1:0] b, input logic [SELW-1:0] c);
        return b[c*DW +: DW];
    endfunction

    task automatic scramble_bus();
        for (int i = 0; i < NCH; i++) samp_bus[i*DW +: DW] = DW'($urandom);
    endtask

    task automatic pulse(input logic d);
        din = d; sclk = 1'b1; wait_n(3);
        sclk = 1'b0; wait_n(3);
    endtask

    task automatic start_slave();
        exp_word = lane_of(samp_bus, chan_m);
        cs_n = 1'b0; wait_n(2);
        chk("R3 status after select fall", status, 1);
        chk("R4 enable off at start", dout_en, 0);
        scramble_bus();
    endtask

    task automatic run_frame(input logic [SELW-1:0] nxt, input bit free);
        for (int k = 1; k <= 16; k++) begin
            din = (k <= SELW) ? nxt[SELW-k] : 1'($urandom);
            sclk = 1'b1; wait_n(2);
            if (k == SELW) begin
                chan_m = nxt;
                chk("R6 channel code latched", chan, chan_m);
            end
            chk("R4 enable after rise", dout_en, (k >= 5) ? 1 : 0);
            wait_n(1);
            sclk = 1'b0; wait_n(2);
            if (k >= 4 && k <= 15) begin
                chk("R4 enable in data window", dout_en, 1);
                chk("R4 data bit", dout, exp_word[DW-1-(k-4)]);
            end else begin
                chk("R4 enable outside window", dout_en, 0);
            end
            chk("R7 status level", status, (k < 16) ? 1 : 0);
            wait_n(1);
        end
        if (free) begin
            sclk = 1'b1; wait_n(2);
            chk("R8 dead clock status", status, 0);
            chk("R8 dead clock enable", dout_en, 0);
            scramble_bus();
            exp_word = lane_of(samp_bus, chan_m);
            wait_n(1);
            sclk = 1'b0; wait_n(2);
            chk("R8 restart status", status, 1);
            scramble_bus();
            wait_n(1);
        end else begin
            pulse(1'b1);
            pulse(1'b0);
            chk("R9 no restart status", status, 0);
            chk("R9 no restart enable", dout_en, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_n(4);
        chk("R1 reset chan", chan, 0);
        chk("R1 reset status", status, 0);
        chk("R1 reset enable", dout_en, 0);
        rst = 1'b0;
        wait_n(2);

        // directed: fixed bus, CH0 now, CH3 next
        samp_bus = {12'hC3A, 12'h5F0, 12'h0FF, 12'hA55};
        start_slave();
        run_frame(2'b11, 1'b0);
        cs_n = 1'b1; wait_n(2);
        chk("R2 status cleared", status, 0);
        chk("R2 enable cleared", dout_en, 0);
        chk("R2 channel kept", chan, 2'b11);
        // R6: CH3 now steers this frame
        samp_bus = {12'h800, 12'h001, 12'h7FF, 12'hFFF};
        start_slave();
        chk("R6 steered lane", exp_word, 12'h800);
        run_frame(2'b01, 1'b0);
        cs_n = 1'b1; wait_n(3);

        for (int f = 0; f < 8; f++) begin
            scramble_bus();
            start_slave();
            run_frame(SELW'($urandom), 1'b0);
            cs_n = 1'b1; wait_n(3);
        end

        // free running
        free_run = 1'b1;
        scramble_bus();
        start_slave();
        for (int f = 0; f < 6; f++) run_frame(SELW'($urandom), 1'b1);
        // select high in the middle of shifting
        pulse(1'b0); pulse(1'b0);
        chan_m = 2'b00;
        for (int k = 0; k < 5; k++) pulse(1'b1);
        cs_n = 1'b1; wait_n(2);
        chk("R2 clear mid frame status", status, 0);
        chk("R2 clear mid frame enable", dout_en, 0);
        free_run = 1'b0;
        wait_n(2);

        // shutdown abort
        scramble_bus();
        start_slave();
        pulse(1'b1); pulse(1'b0);
        chan_m = 2'b10;
        for (int k = 0; k < 4; k++) pulse(1'b0);
        chk("R4 shifting before abort", dout_en, 1);
        shdn = 1'b1; wait_n(2);
        chk("R10 abort status", status, 0);
        chk("R10 abort enable", dout_en, 0);
        shdn = 1'b0; wait_n(2);
        for (int k = 0; k < 6; k++) pulse(1'b1);
        chk("R10 no restart status", status, 0);
        chk("R10 no restart enable", dout_en, 0);
        chk("R10 channel kept", chan, 2'b10);
        cs_n = 1'b1; wait_n(2);

        // select fall during shutdown
        shdn = 1'b1;
        wait_n(1);
        cs_n = 1'b0; wait_n(2);
        chk("R11 status during shutdown", status, 0);
        shdn = 1'b0; wait_n(2);
        chk("R11 status after shutdown drop", status, 0);
        for (int k = 0; k < 6; k++) pulse(1'b0);
        chk("R11 enable stays off", dout_en, 0);
        cs_n = 1'b1; wait_n(2);

        // recovery
        scramble_bus();
        start_slave();
        run_frame(2'b00, 1'b0);
        cs_n = 1'b1; wait_n(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule